// File: doc/BRIEF.md
# DMA Channel Request Priority Arbiter

This block chooses which of eight DMA channels is served next. Each channel has eight candidate request lines. A per-channel 3-bit source select picks one of those lines. An enable bit then gates the selected line, so the channel takes part only while it is switched on. Among the channels that are requesting, the winner is the one with the highest 2-bit software priority. When two or more requesters share that priority, the lowest channel number wins.

Two arbiter copies run side by side. Port 0 serves the memory side and port 1 serves the peripheral side. Both copies see the same channel requests, but each one keeps its own grant and its own transfer-done input. A grant is a registered one-hot vector with a valid flag. It stays fixed until the transfer engine pulses done on that port. In the cycle of that pulse the port arbitrates again.

Top module: `dma_req_arbiter`

## Requirements
- R1: Channel c requests when bit c*8+s of `src_req_i` is set, where s is the value of `ch_sel_i[c*3 +: 3]`; the other seven lines of that channel have no effect.
- R2: A channel whose bit in `ch_en_i` is 0 is never granted, even when its selected line is high.
- R3: Priority `ch_prio_i[c*2 +: 2]` is 2'b00 low, 2'b01 medium, 2'b10 high, 2'b11 ultra high; among requesting channels the highest level wins.
- R4: Among requesting channels at the same highest level, the lowest channel number wins.
- R5: The grant is registered: when a port is free at a rising edge, the winner is taken from the inputs at that edge and shown as exactly one bit of that port's `gnt_o` slice with `gnt_vld_o` high.
- R6: While a port's grant is valid and its done bit is low, its grant does not change, whatever the requests, enables, selects or priorities do.
- R7: A done pulse on a valid port starts a new arbitration at that edge: the port grants the current winner or, if nobody requests, goes idle.
- R8: A port that has no grant shows `gnt_vld_o` low and an all-zero grant slice.
- R9: The two ports are independent: a done pulse on one port never changes the other port's grant.
- R10: During and after reset both ports are idle, with no grant; a done pulse on an idle port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | 64 | Source lines, eight per channel, channel c at bits c*8 +: 8 |
| ch_en_i | input | 8 | Per-channel enable |
| ch_sel_i | input | 24 | Per-channel 3-bit source select |
| ch_prio_i | input | 16 | Per-channel 2-bit software priority |
| done_i | input | 2 | Transfer-done pulse per port (bit 0 memory, bit 1 peripheral) |
| gnt_o | output | 16 | One-hot grant per port, port p at bits p*8 +: 8 |
| gnt_vld_o | output | 2 | Grant-valid per port |

## Verification
Directed patterns each isolate one rule:
- A single channel whose selected line is set is compared with one whose neighbouring, unselected line is set; this separates correct source selection from a wrong index.
- A disabled high-priority requester placed against an enabled low-priority one exposes a missing enable gate.
- Requesters with distinct priority levels in scrambled channel order test the level comparison.
- Requesters at equal levels test the lowest-channel tie-break.
- Changing the requests while a grant is held, and pulsing done on one port only, show hold behaviour and port independence.

A long run of seeded random sparse requests, configurations and done pulses is then compared cycle by cycle against a reference model in the bench. This covers the interplay of the rules above.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   // Picker structure variants selectable by parameter
   localparam int PICK_LINEAR = 0;  // sequential scan, strict-greater keeps lowest index
   localparam int PICK_LEVEL  = 1;  // per-level masks, then lowest-set-bit isolate

   // Port roles
   localparam int PORT_MEM = 0;
   localparam int PORT_PER = 1;

   // Software priority encoding for the default 2-bit field
   typedef enum logic [1:0] {
      PRIO_LOW   = 2'b00,
      PRIO_MED   = 2'b01,
      PRIO_HIGH  = 2'b10,
      PRIO_ULTRA = 2'b11
   } prio_lvl_e;
endpackage

// File: rtl/dma_req_mux.sv
module dma_req_mux #(
   parameter int SEL_W = 3,
   localparam int NUM_SRC = 1 << SEL_W
) (
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               en_i,
   output logic               req_o
);
   // One channel: choose its source line, then gate by enable
   always_comb begin
      req_o = en_i & src_i[sel_i];
   end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int PRIO_W = 2,
   parameter int STYLE  = PICK_LEVEL,
   localparam int NUM_LVL = 1 << PRIO_W
) (
   input  logic [NUM_CH-1:0]        req_i,
   input  logic [NUM_CH*PRIO_W-1:0] prio_i,
   output logic [NUM_CH-1:0]        win_o
);
   generate
      if (STYLE == PICK_LINEAR) begin : g_linear
         logic [PRIO_W-1:0] best_p;
         logic              found;
         always_comb begin
            win_o  = '0;
            best_p = '0;
            found  = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
               if (req_i[c] && (!found || prio_i[c*PRIO_W +: PRIO_W] > best_p)) begin
                  found  = 1'b1;
                  best_p = prio_i[c*PRIO_W +: PRIO_W];
                  win_o  = '0;
                  win_o[c] = 1'b1;
               end
            end
         end
      end else begin : g_level
         logic [NUM_LVL-1:0][NUM_CH-1:0] lvl_req;
         logic [NUM_CH-1:0]              top_set;
         for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
               assign lvl_req[l][c] = req_i[c] &&
                                      (prio_i[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
            end
         end
         always_comb begin
            top_set = '0;
            for (int l = 0; l < NUM_LVL; l++) begin
               if (|lvl_req[l]) top_set = lvl_req[l];
            end
            win_o = top_set & (~top_set + NUM_CH'(1));
         end
      end
   endgenerate
endmodule

// File: rtl/dma_grant_hold.sv
module dma_grant_hold #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] elig_i,
   input  logic [NUM_CH-1:0] win_i,
   input  logic              done_i,
   output logic [NUM_CH-1:0] gnt_o,
   output logic              vld_o
);
   logic [NUM_CH-1:0] gnt_q;
   logic              vld_q;
   logic              take;

   assign take  = !vld_q || done_i;
   assign gnt_o = gnt_q;
   assign vld_o = vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q <= '0;
         vld_q <= 1'b0;
      end else if (take) begin
         gnt_q <= win_i;
         vld_q <= |win_i;
      end
   end

   // R5: a valid grant names exactly one channel
   a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> ($countones(gnt_q) == 1));

   // R8: no grant means an all-zero vector
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q |-> (gnt_q == '0));

   // R6: held grant stays put until done
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !done_i) |=> (vld_q && $stable(gnt_q)));

   // R7: rearbitration with nobody eligible goes idle
   a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(|elig_i)) |=> !vld_q);

   // R2: a new grant goes to a channel that was eligible
   a_r2_gnt_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (|elig_i)) |=> (vld_q && ((gnt_q & $past(elig_i)) != '0)));
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int SEL_W      = 3,
   parameter int PRIO_W     = 2,
   parameter int NUM_PORTS  = 2,
   parameter int PICK_STYLE = PICK_LEVEL,
   localparam int NUM_SRC   = 1 << SEL_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CH*NUM_SRC-1:0]     src_req_i,
   input  logic [NUM_CH-1:0]             ch_en_i,
   input  logic [NUM_CH*SEL_W-1:0]       ch_sel_i,
   input  logic [NUM_CH*PRIO_W-1:0]      ch_prio_i,
   input  logic [NUM_PORTS-1:0]          done_i,
   output logic [NUM_PORTS*NUM_CH-1:0]   gnt_o,
   output logic [NUM_PORTS-1:0]          gnt_vld_o
);
   // Elaboration-time parameter checks
   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("NUM_CH must be at least 2");
      end
      if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
         $error("SEL_W must be in 1..6");
      end
      if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
         $error("PRIO_W must be in 1..4");
      end
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("NUM_PORTS must be at least 1");
      end
      if (PICK_STYLE != PICK_LINEAR && PICK_STYLE != PICK_LEVEL) begin : g_bad_style
         $error("PICK_STYLE unknown");
      end
   endgenerate

   logic [NUM_CH-1:0] ch_req;

   // Per-channel source selection and enable gating (R1, R2)
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         dma_req_mux #(.SEL_W(SEL_W)) u_mux (
            .src_i (src_req_i[c*NUM_SRC +: NUM_SRC]),
            .sel_i (ch_sel_i[c*SEL_W +: SEL_W]),
            .en_i  (ch_en_i[c]),
            .req_o (ch_req[c])
         );
      end
   endgenerate

   // One independent picker and grant register per port (R9)
   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         logic [NUM_CH-1:0] win;

         dma_prio_pick #(
            .NUM_CH (NUM_CH),
            .PRIO_W (PRIO_W),
            .STYLE  (PICK_STYLE)
         ) u_pick (
            .req_i  (ch_req),
            .prio_i (ch_prio_i),
            .win_o  (win)
         );

         dma_grant_hold #(.NUM_CH(NUM_CH)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .elig_i (ch_req),
            .win_i  (win),
            .done_i (done_i[p]),
            .gnt_o  (gnt_o[p*NUM_CH +: NUM_CH]),
            .vld_o  (gnt_vld_o[p])
         );
      end
   endgenerate
endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
   localparam int NCH = 8;
   localparam int NSRC = 8;
   localparam int NP = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [63:0]    src = '0;
   logic [7:0]     en = '0;
   logic [23:0]    sel = '0;
   logic [15:0]    prio = '0;
   logic [1:0]     done = '0;
   logic [15:0]    gnt;
   logic [1:0]     vld;

   logic [7:0]     m_gnt [NP];
   logic           m_vld [NP];

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dma_req_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .src_req_i(src), .ch_en_i(en),
      .ch_sel_i(sel), .ch_prio_i(prio), .done_i(done),
      .gnt_o(gnt), .gnt_vld_o(vld)
   );

   // Reference picker from R1..R4
   function automatic logic [7:0] f_pick(input logic [63:0] s, input logic [7:0] e,
                                         input logic [23:0] sl, input logic [15:0] p);
      int best = -1;
      int bp = -1;
      for (int c = 0; c < NCH; c++) begin
         int idx = c * NSRC + int'(sl[c*3 +: 3]);
         if (e[c] && s[idx] && int'(p[c*2 +: 2]) > bp) begin
            best = c;
            bp = int'(p[c*2 +: 2]);
         end
      end
      return (best < 0) ? 8'h00 : (8'h01 << best);
   endfunction

   task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual vld/gnt=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk_ports(input string tag);
      for (int p = 0; p < NP; p++)
         chk({vld[p], gnt[p*8 +: 8]}, {m_vld[p], m_gnt[p]},
             $sformatf("%s port%0d", tag, p));
   endtask

   // One clock: model update at the edge, compare at the falling edge
   task automatic step(input string tag);
      @(posedge clk);
      for (int p = 0; p < NP; p++) begin
         if (!rst_n) begin
            m_vld[p] = 1'b0; m_gnt[p] = '0;
         end else if (!m_vld[p] || done[p]) begin
            m_gnt[p] = f_pick(src, en, sel, prio);
            m_vld[p] = |m_gnt[p];
         end
      end
      @(negedge clk);
      chk_ports(tag);
      done = '0;
   endtask

   task automatic release_all();
      src = '0; done = 2'b11;
      step("R7 release");
   endtask

   task automatic set_ch(input int c, input logic e, input logic [2:0] s, input logic [1:0] p);
      en[c] = e; sel[c*3 +: 3] = s; prio[c*2 +: 2] = p;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int p = 0; p < NP; p++) begin m_vld[p] = 0; m_gnt[p] = '0; end
      step("R10 in reset");
      step("R10 in reset");
      rst_n = 1'b1;
      chk({vld[0], gnt[7:0]}, 9'h000, "R10 reset idle port0");
      chk({vld[1], gnt[15:8]}, 9'h000, "R10 reset idle port1");

      // R1: ch3 select 5, its line 3*8+5 set
      set_ch(3, 1'b1, 3'd5, 2'b00);
      src[29] = 1'b1;
      step("R1 selected line");
      chk({vld[0], gnt[7:0]}, {1'b1, 8'h08}, "R1 explicit ch3");
      release_all();
      // R1: unselected neighbour line has no effect
      src[28] = 1'b1;
      step("R1 unselected line");
      chk({vld[0], gnt[7:0]}, 9'h000, "R1 explicit none");
      release_all();

      // R2: disabled ultra ch1 vs enabled low ch6
      set_ch(1, 1'b0, 3'd2, 2'b11);
      set_ch(6, 1'b1, 3'd7, 2'b00);
      src[1*8+2] = 1'b1; src[6*8+7] = 1'b1;
      step("R2 disabled ignored");
      chk({vld[1], gnt[15:8]}, {1'b1, 8'h40}, "R2 explicit ch6");
      release_all();

      // R3: ch0 medium, ch5 ultra, ch7 high
      en = '0;
      set_ch(0, 1'b1, 3'd0, 2'b01);
      set_ch(5, 1'b1, 3'd1, 2'b11);
      set_ch(7, 1'b1, 3'd3, 2'b10);
      src[0] = 1'b1; src[5*8+1] = 1'b1; src[7*8+3] = 1'b1;
      step("R3 highest level");
      chk({vld[0], gnt[7:0]}, {1'b1, 8'h20}, "R3 explicit ch5");
      release_all();

      // R4: ch2 and ch6 both high
      en = '0;
      set_ch(2, 1'b1, 3'd4, 2'b10);
      set_ch(6, 1'b1, 3'd4, 2'b10);
      src[6*8+4] = 1'b1; src[2*8+4] = 1'b1;
      step("R4 tie lowest");
      chk({vld[0], gnt[7:0]}, {1'b1, 8'h04}, "R4 explicit ch2");

      // R6: raise ch6 to ultra, no done: grant stays on ch2
      set_ch(6, 1'b1, 3'd4, 2'b11);
      step("R6 hold");
      chk({vld[1], gnt[15:8]}, {1'b1, 8'h04}, "R6 explicit held");

      // R7/R9: done on port 0 only
      done = 2'b01;
      step("R7 R9 single done");
      chk({vld[0], gnt[7:0]}, {1'b1, 8'h40}, "R7 explicit new winner");
      chk({vld[1], gnt[15:8]}, {1'b1, 8'h04}, "R9 explicit other port held");
      release_all();

      // R10: done on idle ports is ignored
      done = 2'b11;
      step("R10 done idle");
      chk({vld, gnt}, 18'h0, "R10 explicit idle");

      // Random phase: every check compares against the model (R1..R9)
      for (int i = 0; i < 4000; i++) begin
         src  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         en   = 8'($urandom);
         sel  = 24'($urandom);
         prio = 16'($urandom);
         done = {($urandom % 3) == 0, ($urandom % 3) == 0};
         step("R3 R4 R6 R9 random");
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule